// File: doc/BRIEF.md
# Set-Associative Tag Directory with Coherence State

This block holds the tags and line states for a 32KB data cache with 64-byte lines, 64 sets and 8 ways. A lookup picks its set from address bits that are the same in the virtual and physical address, so the set can be read while a separate translation path produces the physical page number. In the next cycle the block reports hit or miss, the matching way and that way's four-value coherence state. On a miss it requests the full physical line address from the next level.

Line fills choose a victim way on their own and report the way, state and page number they displaced, so the caller can write back dirty data. A separate state-update port changes the state of one named way, for example when a store upgrades Exclusive to Modified. A synchronous reset and a one-cycle invalidate-all input both empty the whole directory.

Top module: `set_assoc_tag_dir`

## Requirements
- R1: After reset or a cycle with `invAll` high, every way reads as Invalid: lookups miss, and the next fill into any set takes way 0.
- R2: The set is bits 11..6 of the 12-bit address input of each port. Bits 5..0 change nothing.
- R3: A lookup hits when a way of the selected set holds the same 24-bit page number and a state other than Invalid. One cycle after `lookupValid`, `respValid` and `respHit` are high, and `respWay` and `respState` give the way and its state. States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R4: On a missed lookup, `missReq` is high one cycle later and `missLineAddr` equals {page number, set}. At the same time `respHit`, `respWay` and `respState` are 0. Example: address 0x0A0 with page 0x80001 requests 0x2000042.
- R5: A fill writes into the lowest-numbered Invalid way of its set, if the set has one.
- R6: A fill into a full set replaces the way chosen by a 7-bit tree pseudo-LRU kept for each set. Node n has children 2n+1 and 2n+2, and a node bit of 0 points the victim toward the lower half. Every hit and every fill re-points the nodes on the path to the way that was used away from it.
- R7: One cycle after a fill, `evictValid` is high and `evictWay`, `evictState` and `evictPpn` give the way written and the state and page number it held before.
- R8: An update writes `updState` into way `updWay` of the addressed set. The update is dropped when a fill is accepted in the same cycle.
- R9: In a cycle with `invAll` high, lookups, fills and updates are ignored, so `respValid` and `evictValid` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| invAll | input | 1 | Invalidate every entry and clear replacement state |
| lookupValid | input | 1 | Lookup strobe |
| lookupVa | input | 12 | Untranslated low address bits of the lookup |
| lookupPpn | input | 24 | Physical page number from translation |
| fillValid | input | 1 | Fill strobe |
| fillVa | input | 12 | Low address bits of the line being filled |
| fillPpn | input | 24 | Page number of the line being filled |
| fillState | input | 2 | State given to the new line |
| updValid | input | 1 | State update strobe |
| updVa | input | 12 | Low address bits selecting the set to update |
| updWay | input | 3 | Way to update |
| updState | input | 2 | New state |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respWay | output | 3 | Way that hit |
| respState | output | 2 | State of the way that hit |
| missReq | output | 1 | Request to next level |
| missLineAddr | output | 30 | Physical line address of the miss |
| evictValid | output | 1 | Fill result valid |
| evictWay | output | 3 | Way written by the fill |
| evictState | output | 2 | Previous state of that way |
| evictPpn | output | 24 | Previous page number of that way |

## Verification
Most faults in this block stay hidden until a later access reaches them. A state written into the wrong way, or a skipped state reset, shows up only at the next lookup of that set or the next fill there, one cycle after that strobe. A pseudo-LRU bit that is stored wrong is harder to see: the victim way reported by a fill into a full set changes only when the fault lies on the path the tree walk takes. For that reason the sequence fills a set completely and then mixes hits and fills on it, so that the tree walk takes both branches at every level. Results are only sampled when they are visible at the ports.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    LS_INVALID   = 2'd0,
    LS_SHARED    = 2'd1,
    LS_EXCLUSIVE = 2'd2,
    LS_MODIFIED  = 2'd3
  } lineState_e;

  // Write strobes from the control half to the storage half.
  typedef struct packed {
    logic clearAll;
    logic fillWr;
    logic updWr;
    logic hitTouch;
  } dirStrobe_t;

endpackage

// File: rtl/tagdir_datapath.sv
module tagdir_datapath
  import tagdir_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dirStrobe_t                     strobe,
  input  logic [$clog2(SETS)-1:0]        lkIdx,
  input  logic [$clog2(SETS)-1:0]        fillIdx,
  input  logic [$clog2(SETS)-1:0]        updIdx,
  input  logic [$clog2(WAYS)-1:0]        fillWay,
  input  logic [$clog2(WAYS)-1:0]        updWay,
  input  logic [TAG_W-1:0]               fillTag,
  input  logic [1:0]                     fillState,
  input  logic [1:0]                     updState,
  input  logic [WAYS-2:0]                lkTreeNext,
  input  logic [WAYS-2:0]                fillTreeNext,
  output logic [WAYS-1:0][TAG_W-1:0]     lkTags,
  output logic [WAYS-1:0][1:0]           lkStates,
  output logic [WAYS-2:0]                lkTree,
  output logic [WAYS-1:0][TAG_W-1:0]     fillTags,
  output logic [WAYS-1:0][1:0]           fillStates,
  output logic [WAYS-2:0]                fillTree
);

  localparam int TREE_W = WAYS - 1;

  logic [WAYS-1:0][TAG_W-1:0] tagMem   [SETS];
  logic [WAYS-1:0][1:0]       stateMem [SETS];
  logic [TREE_W-1:0]          treeMem  [SETS];

  // Two read ports: one for the lookup set, one for the fill set.
  assign lkTags     = tagMem[lkIdx];
  assign lkStates   = stateMem[lkIdx];
  assign lkTree     = treeMem[lkIdx];
  assign fillTags   = tagMem[fillIdx];
  assign fillStates = stateMem[fillIdx];
  assign fillTree   = treeMem[fillIdx];

  // Tags carry no reset; a tag is meaningless while its state is Invalid.
  always_ff @(posedge clk) begin
    if (strobe.fillWr) begin
      tagMem[fillIdx][fillWay] <= fillTag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      for (int s = 0; s < SETS; s++) begin
        stateMem[s] <= '0;
        treeMem[s]  <= '0;
      end
    end else begin
      if (strobe.hitTouch) begin
        treeMem[lkIdx] <= lkTreeNext;
      end
      // A fill in the same set is written last and so wins.
      if (strobe.fillWr) begin
        stateMem[fillIdx][fillWay] <= fillState;
        treeMem[fillIdx]           <= fillTreeNext;
      end else if (strobe.updWr) begin
        stateMem[updIdx][updWay] <= updState;
      end
    end
  end

endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:0][1:0]    states,
  input  logic [WAYS-2:0]         tree,
  output logic [$clog2(WAYS)-1:0] victimWay
);

  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  isFree;
  logic [WAY_W-1:0] freeWay;
  logic [WAY_W-1:0] treeWay;
  logic             anyFree;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_free
      assign isFree[gw] = (states[gw] == 2'd0);
    end
  endgenerate

  // Lowest-numbered free way: scanning downward leaves the smallest.
  always_comb begin
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (isFree[w]) freeWay = WAY_W'(w);
    end
  end

  assign anyFree = |isFree;

  // Walk the tree from the root; each bit steers toward the victim.
  always_comb begin
    int node;
    node    = 0;
    treeWay = '0;
    for (int l = 0; l < WAY_W; l++) begin
      treeWay[WAY_W-1-l] = tree[node];
      node = 2 * node + 1 + int'(tree[node]);
    end
  end

  assign victimWay = anyFree ? freeWay : treeWay;

endmodule

// File: rtl/tagdir_ctrl.sv
module tagdir_ctrl
  import tagdir_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           invAll,
  input  logic                           lookupValid,
  input  logic [$clog2(SETS)-1:0]        lookupIdx,
  input  logic [TAG_W-1:0]               lookupTag,
  input  logic                           fillValid,
  input  logic                           updValid,
  input  logic [WAYS-1:0][TAG_W-1:0]     lkTags,
  input  logic [WAYS-1:0][1:0]           lkStates,
  input  logic [WAYS-2:0]                lkTree,
  input  logic [WAYS-1:0][TAG_W-1:0]     fillTags,
  input  logic [WAYS-1:0][1:0]           fillStates,
  input  logic [WAYS-2:0]                fillTree,
  output dirStrobe_t                     strobe,
  output logic [$clog2(WAYS)-1:0]        fillWay,
  output logic [WAYS-2:0]                lkTreeNext,
  output logic [WAYS-2:0]                fillTreeNext,
  output logic                           respValid,
  output logic                           respHit,
  output logic [$clog2(WAYS)-1:0]        respWay,
  output logic [1:0]                     respState,
  output logic                           missReq,
  output logic [TAG_W+$clog2(SETS)-1:0]  missLineAddr,
  output logic                           evictValid,
  output logic [$clog2(WAYS)-1:0]        evictWay,
  output logic [1:0]                     evictState,
  output logic [TAG_W-1:0]               evictPpn
);

  localparam int WAY_W  = $clog2(WAYS);
  localparam int TREE_W = WAYS - 1;

  // Re-point every node on the path to way w away from it.
  function automatic logic [TREE_W-1:0] treeTouch(input logic [TREE_W-1:0] t,
                                                  input logic [WAY_W-1:0]  w);
    logic [TREE_W-1:0] r;
    int node;
    r    = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node    = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic             anyHit;
  logic             lookupTake;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hitVec[gw] = (lkStates[gw] != LS_INVALID) && (lkTags[gw] == lookupTag);
    end
  endgenerate

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign anyHit     = |hitVec;
  assign lookupTake = lookupValid && !invAll;

  tagdir_victim #(.WAYS(WAYS)) u_victim (
    .states    (fillStates),
    .tree      (fillTree),
    .victimWay (fillWay)
  );

  assign lkTreeNext   = treeTouch(lkTree, hitWay);
  assign fillTreeNext = treeTouch(fillTree, fillWay);

  always_comb begin
    strobe.clearAll = invAll;
    strobe.hitTouch = lookupTake && anyHit;
    strobe.fillWr   = fillValid && !invAll;
    strobe.updWr    = updValid && !fillValid && !invAll;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid    <= 1'b0;
      respHit      <= 1'b0;
      respWay      <= '0;
      respState    <= '0;
      missReq      <= 1'b0;
      missLineAddr <= '0;
      evictValid   <= 1'b0;
      evictWay     <= '0;
      evictState   <= '0;
      evictPpn     <= '0;
    end else begin
      respValid    <= lookupTake;
      respHit      <= lookupTake && anyHit;
      respWay      <= anyHit ? hitWay : '0;
      respState    <= anyHit ? lkStates[hitWay] : LS_INVALID;
      missReq      <= lookupTake && !anyHit;
      missLineAddr <= {lookupTag, lookupIdx};
      evictValid   <= strobe.fillWr;
      evictWay     <= fillWay;
      evictState   <= fillStates[fillWay];
      evictPpn     <= fillTags[fillWay];
    end
  end

endmodule

// File: rtl/set_assoc_tag_dir.sv
module set_assoc_tag_dir
  import tagdir_pkg::*;
#(
  parameter int PA_W       = 36,
  parameter int SETS       = 64,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W       = $clog2(LINE_BYTES),
  localparam int IDX_W       = $clog2(SETS),
  localparam int VA_W        = OFF_W + IDX_W,
  localparam int TAG_W       = PA_W - VA_W,
  localparam int WAY_W       = $clog2(WAYS),
  localparam int LINE_ADDR_W = PA_W - OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   invAll,
  input  logic                   lookupValid,
  input  logic [VA_W-1:0]        lookupVa,
  input  logic [TAG_W-1:0]       lookupPpn,
  input  logic                   fillValid,
  input  logic [VA_W-1:0]        fillVa,
  input  logic [TAG_W-1:0]       fillPpn,
  input  logic [1:0]             fillState,
  input  logic                   updValid,
  input  logic [VA_W-1:0]        updVa,
  input  logic [WAY_W-1:0]       updWay,
  input  logic [1:0]             updState,
  output logic                   respValid,
  output logic                   respHit,
  output logic [WAY_W-1:0]       respWay,
  output logic [1:0]             respState,
  output logic                   missReq,
  output logic [LINE_ADDR_W-1:0] missLineAddr,
  output logic                   evictValid,
  output logic [WAY_W-1:0]       evictWay,
  output logic [1:0]             evictState,
  output logic [TAG_W-1:0]       evictPpn
);

  dirStrobe_t                 strobe;
  logic [WAY_W-1:0]           fillWay;
  logic [WAYS-2:0]            lkTreeNext, fillTreeNext, lkTree, fillTree;
  logic [WAYS-1:0][TAG_W-1:0] lkTags, fillTags;
  logic [WAYS-1:0][1:0]       lkStates, fillStates;
  logic [IDX_W-1:0]           lookupIdx, fillIdx, updIdx;

  // Offset bits below OFF_W never reach the directory.
  assign lookupIdx = lookupVa[VA_W-1:OFF_W];
  assign fillIdx   = fillVa[VA_W-1:OFF_W];
  assign updIdx    = updVa[VA_W-1:OFF_W];

  tagdir_datapath #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .lkIdx        (lookupIdx),
    .fillIdx      (fillIdx),
    .updIdx       (updIdx),
    .fillWay      (fillWay),
    .updWay       (updWay),
    .fillTag      (fillPpn),
    .fillState    (fillState),
    .updState     (updState),
    .lkTreeNext   (lkTreeNext),
    .fillTreeNext (fillTreeNext),
    .lkTags       (lkTags),
    .lkStates     (lkStates),
    .lkTree       (lkTree),
    .fillTags     (fillTags),
    .fillStates   (fillStates),
    .fillTree     (fillTree)
  );

  tagdir_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .invAll       (invAll),
    .lookupValid  (lookupValid),
    .lookupIdx    (lookupIdx),
    .lookupTag    (lookupPpn),
    .fillValid    (fillValid),
    .updValid     (updValid),
    .lkTags       (lkTags),
    .lkStates     (lkStates),
    .lkTree       (lkTree),
    .fillTags     (fillTags),
    .fillStates   (fillStates),
    .fillTree     (fillTree),
    .strobe       (strobe),
    .fillWay      (fillWay),
    .lkTreeNext   (lkTreeNext),
    .fillTreeNext (fillTreeNext),
    .respValid    (respValid),
    .respHit      (respHit),
    .respWay      (respWay),
    .respState    (respState),
    .missReq      (missReq),
    .missLineAddr (missLineAddr),
    .evictValid   (evictValid),
    .evictWay     (evictWay),
    .evictState   (evictState),
    .evictPpn     (evictPpn)
  );

endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int OFF_W = 6,
  parameter int VA_W  = 12,
  parameter int TAG_W = 24,
  parameter int WAY_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             invAll,
  input logic             lookupValid,
  input logic [VA_W-1:0]  lookupVa,
  input logic [TAG_W-1:0] lookupPpn,
  input logic             fillValid,
  input logic [VA_W-1:0]  fillVa,
  input logic [TAG_W-1:0] fillPpn,
  input logic [1:0]       fillState,
  input logic             respValid,
  input logic             respHit,
  input logic [WAY_W-1:0] respWay,
  input logic [1:0]       respState,
  input logic             missReq,
  input logic             evictValid,
  input logic [WAY_W-1:0] evictWay
);

  // R3: a hit never reports the Invalid state
  assert_hit_state_R3: assert property (@(posedge clk) disable iff (rst)
    respHit |-> (respValid && respState != 2'd0));

  // R4: a miss request carries zeroed hit fields
  assert_miss_fields_R4: assert property (@(posedge clk) disable iff (rst)
    missReq |-> (respValid && !respHit && respState == 2'd0 && respWay == '0));

  // R3: a result only follows an accepted lookup
  assert_resp_origin_R3: assert property (@(posedge clk) disable iff (rst)
    respValid |-> ($past(lookupValid) && !$past(invAll)));

  // R7: a fill report only follows an accepted fill
  assert_evict_origin_R7: assert property (@(posedge clk) disable iff (rst)
    evictValid |-> ($past(fillValid) && !$past(invAll)));

  // R9: invalidate-all silences both result channels
  assert_inv_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    invAll |=> (!respValid && !evictValid));

  // R5: a line just filled is found by the next lookup in the way reported
  assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (lookupValid && !invAll && evictValid && $past(fillState) != 2'd0 &&
     lookupVa[VA_W-1:OFF_W] == $past(fillVa[VA_W-1:OFF_W]) &&
     lookupPpn == $past(fillPpn))
    |=> (respHit && respWay == $past(evictWay)));

endmodule

bind set_assoc_tag_dir tagdir_checker #(
  .OFF_W (OFF_W),
  .VA_W  (VA_W),
  .TAG_W (TAG_W),
  .WAY_W (WAY_W)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .invAll      (invAll),
  .lookupValid (lookupValid),
  .lookupVa    (lookupVa),
  .lookupPpn   (lookupPpn),
  .fillValid   (fillValid),
  .fillVa      (fillVa),
  .fillPpn     (fillPpn),
  .fillState   (fillState),
  .respValid   (respValid),
  .respHit     (respHit),
  .respWay     (respWay),
  .respState   (respState),
  .missReq     (missReq),
  .evictValid  (evictValid),
  .evictWay    (evictWay)
);

// File: tb/set_assoc_tag_dir_tb.sv
module set_assoc_tag_dir_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        invAll;
  logic        lookupValid;
  logic [11:0] lookupVa;
  logic [23:0] lookupPpn;
  logic        fillValid;
  logic [11:0] fillVa;
  logic [23:0] fillPpn;
  logic [1:0]  fillState;
  logic        updValid;
  logic [11:0] updVa;
  logic [2:0]  updWay;
  logic [1:0]  updState;
  logic        respValid, respHit, missReq, evictValid;
  logic [2:0]  respWay, evictWay;
  logic [1:0]  respState, evictState;
  logic [29:0] missLineAddr;
  logic [23:0] evictPpn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  set_assoc_tag_dir u_dut (
    .clk(clk), .rst(rst), .invAll(invAll),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .lookupPpn(lookupPpn),
    .fillValid(fillValid), .fillVa(fillVa), .fillPpn(fillPpn), .fillState(fillState),
    .updValid(updValid), .updVa(updVa), .updWay(updWay), .updState(updState),
    .respValid(respValid), .respHit(respHit), .respWay(respWay), .respState(respState),
    .missReq(missReq), .missLineAddr(missLineAddr),
    .evictValid(evictValid), .evictWay(evictWay), .evictState(evictState),
    .evictPpn(evictPpn)
  );

  typedef struct packed {
    logic [1:0]  op;      // 0 lookup, 1 fill, 2 update
    logic [11:0] va;
    logic [23:0] ppn;
    logic [1:0]  st;
    logic [2:0]  way;
    logic        expHit;
    logic [2:0]  expWay;
    logic [1:0]  expSt;
    logic [23:0] expPpn;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 12'h0A0, 24'h080001, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // R4 miss, worked example
    '{2'd1, 12'h080, 24'h080001, 2'd2, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // R5 way 0
    '{2'd0, 12'h0A0, 24'h080001, 2'd0, 3'd0, 1'b1, 3'd0, 2'd2, 24'h0},      // R3 hit E
    '{2'd0, 12'h0BF, 24'h080001, 2'd0, 3'd0, 1'b1, 3'd0, 2'd2, 24'h0},      // R2 offset ignored
    '{2'd0, 12'h080, 24'h080002, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // R4 tag mismatch
    '{2'd1, 12'h0A5, 24'h000010, 2'd1, 3'd0, 1'b0, 3'd1, 2'd0, 24'h0},      // R5 way 1
    '{2'd0, 12'h080, 24'h000010, 2'd0, 3'd0, 1'b1, 3'd1, 2'd1, 24'h0},      // R3 hit S
    '{2'd2, 12'h080, 24'h0,      2'd3, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // R8 E->M
    '{2'd0, 12'h080, 24'h080001, 2'd0, 3'd0, 1'b1, 3'd0, 2'd3, 24'h0},      // R8 sees M
    '{2'd0, 12'h0C0, 24'h080001, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // R2 other set
    '{2'd1, 12'h140, 24'h000100, 2'd3, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000101, 2'd3, 3'd0, 1'b0, 3'd1, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000102, 2'd3, 3'd0, 1'b0, 3'd2, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000103, 2'd3, 3'd0, 1'b0, 3'd3, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000104, 2'd3, 3'd0, 1'b0, 3'd4, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000105, 2'd3, 3'd0, 1'b0, 3'd5, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000106, 2'd3, 3'd0, 1'b0, 3'd6, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000107, 2'd3, 3'd0, 1'b0, 3'd7, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000200, 2'd2, 3'd0, 1'b0, 3'd0, 2'd3, 24'h000100}, // R6 tree -> 0, R7
    '{2'd0, 12'h140, 24'h000102, 2'd0, 3'd0, 1'b1, 3'd2, 2'd3, 24'h0},      // R6 touch on hit
    '{2'd1, 12'h140, 24'h000300, 2'd2, 3'd0, 1'b0, 3'd4, 2'd3, 24'h000104}, // R6 tree -> 4
    '{2'd0, 12'h140, 24'h000104, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},      // evicted line misses
    '{2'd0, 12'h140, 24'h000300, 2'd0, 3'd0, 1'b1, 3'd4, 2'd2, 24'h0},
    '{2'd2, 12'h140, 24'h0,      2'd0, 3'd6, 1'b0, 3'd0, 2'd0, 24'h0},      // R8 way 6 -> I
    '{2'd0, 12'h140, 24'h000106, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 24'h0},
    '{2'd1, 12'h140, 24'h000400, 2'd1, 3'd0, 1'b0, 3'd6, 2'd0, 24'h0},      // R5 free way beats tree
    '{2'd0, 12'h140, 24'h000400, 2'd0, 3'd0, 1'b1, 3'd6, 2'd1, 24'h0},
    '{2'd0, 12'h140, 24'h000200, 2'd0, 3'd0, 1'b1, 3'd0, 2'd2, 24'h0},
    '{2'd0, 12'h140, 24'h000101, 2'd0, 3'd0, 1'b1, 3'd1, 2'd3, 24'h0},
    '{2'd1, 12'h140, 24'h000500, 2'd1, 3'd0, 1'b0, 3'd5, 2'd3, 24'h000105}  // R6 tree -> 5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    invAll = 0; lookupValid = 0; fillValid = 0; updValid = 0;
  endtask

  // Called at a falling edge; returns at the falling edge after the strobe edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic checkLookup(input logic [11:0] va, input logic [23:0] ppn,
                             input logic eHit, input logic [2:0] eWay,
                             input logic [1:0] eSt);
    chk(respValid == 1'b1, "R3 respValid", 32'(respValid), 32'd1);
    chk(respHit == eHit, eHit ? "R3 respHit" : "R4 respHit", 32'(respHit), 32'(eHit));
    chk(respWay == eWay, "R3 respWay", 32'(respWay), 32'(eWay));
    chk(respState == eSt, "R3 respState", 32'(respState), 32'(eSt));
    chk(missReq == !eHit, "R4 missReq", 32'(missReq), 32'(!eHit));
    if (!eHit)
      chk(missLineAddr == {ppn, va[11:6]}, "R4 missLineAddr", 32'(missLineAddr),
          32'({ppn, va[11:6]}));
  endtask

  task automatic checkFill(input logic [2:0] eWay, input logic [1:0] eSt,
                           input logic [23:0] ePpn);
    chk(evictValid == 1'b1, "R7 evictValid", 32'(evictValid), 32'd1);
    chk(evictWay == eWay, "R5/R6 evictWay", 32'(evictWay), 32'(eWay));
    chk(evictState == eSt, "R7 evictState", 32'(evictState), 32'(eSt));
    if (eSt != 2'd0)
      chk(evictPpn == ePpn, "R7 evictPpn", 32'(evictPpn), 32'(ePpn));
  endtask

  task automatic doLookup(input logic [11:0] va, input logic [23:0] ppn);
    lookupValid = 1; lookupVa = va; lookupPpn = ppn;
    step();
  endtask

  task automatic doFill(input logic [11:0] va, input logic [23:0] ppn, input logic [1:0] st);
    fillValid = 1; fillVa = va; fillPpn = ppn; fillState = st;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    lookupVa = '0; lookupPpn = '0; fillVa = '0; fillPpn = '0; fillState = '0;
    updVa = '0; updWay = '0; updState = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state of the result channels
    chk(respValid == 0, "R1 respValid after reset", 32'(respValid), 0);
    chk(evictValid == 0, "R1 evictValid after reset", 32'(evictValid), 0);
    chk(missReq == 0, "R1 missReq after reset", 32'(missReq), 0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        2'd0: begin
          doLookup(VEC[i].va, VEC[i].ppn);
          checkLookup(VEC[i].va, VEC[i].ppn, VEC[i].expHit, VEC[i].expWay, VEC[i].expSt);
        end
        2'd1: begin
          doFill(VEC[i].va, VEC[i].ppn, VEC[i].st);
          checkFill(VEC[i].expWay, VEC[i].expSt, VEC[i].expPpn);
        end
        default: begin
          updValid = 1; updVa = VEC[i].va; updWay = VEC[i].way; updState = VEC[i].st;
          step();
        end
      endcase
    end

    // R8: update dropped when a fill lands in the same cycle
    fillValid = 1; fillVa = 12'h240; fillPpn = 24'h000055; fillState = 2'd1;
    updValid = 1; updVa = 12'h240; updWay = 3'd0; updState = 2'd3;
    step();
    checkFill(3'd0, 2'd0, 24'h0);
    doLookup(12'h240, 24'h000055);
    checkLookup(12'h240, 24'h000055, 1'b1, 3'd0, 2'd1);  // R8 state stays Shared

    // R9: invalidate-all with lookup and fill in the same cycle
    invAll = 1;
    lookupValid = 1; lookupVa = 12'h080; lookupPpn = 24'h080001;
    fillValid = 1; fillVa = 12'h300; fillPpn = 24'h000777; fillState = 2'd2;
    step();
    chk(respValid == 0, "R9 respValid", 32'(respValid), 0);
    chk(evictValid == 0, "R9 evictValid", 32'(evictValid), 0);

    // R1: everything now reads Invalid, tree cleared
    doLookup(12'h080, 24'h080001);
    checkLookup(12'h080, 24'h080001, 1'b0, 3'd0, 2'd0);
    doLookup(12'h300, 24'h000777);                        // R9 fill was dropped
    checkLookup(12'h300, 24'h000777, 1'b0, 3'd0, 2'd0);
    doFill(12'h140, 24'h000600, 2'd3);
    checkFill(3'd0, 2'd0, 24'h0);                          // R1 first fill takes way 0

    // R1: synchronous reset mid-run
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    doLookup(12'h140, 24'h000600);
    checkLookup(12'h140, 24'h000600, 1'b0, 3'd0, 2'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule